// File: doc/BRIEF.md
# Configurable Memory-Map Chip-Select Decoder

This block turns every address on a 24-bit memory-mapped CPU bus into exactly one device select. The space is cut into twelve fixed windows. The three low I/O windows always go to their device. The other windows are routed by individual bits of three byte-wide configuration registers, by an active-low cartridge-present pin and, in the two low ROM windows, by the direction of the access. When no device claims an address, a separate "none" output is raised so that an external expansion may decode the address itself.

The configuration registers sit at fixed I/O addresses inside the peripheral window. Software writes them through the same bus, and each register reads back its stored value. The decode path is purely combinational from address, direction, pin and register state. The register writes are clocked and use a synchronous active-low reset.

The block also gives a flash offset equal to the low 19 address bits whenever the on-board flash is selected. As a result, the upper flash window and the low ROM windows land on the same flash bytes.

Top module: `memmap_decoder`

## Requirements
- R1: After reset all three configuration registers read 0. In that state, 0x000000 selects on-CPU RAM, 0x00E000 selects on-CPU mask ROM, and 0x008000 gives none.
- R2: A bus write (bus_en=1, bus_wr=1) to 0x00DF27 (chip-select control), 0x00DF40 (bus control) or 0x00DF41 (speed control) loads bus_wdata on that clock edge. A bus read (bus_en=1, bus_wr=0) of those addresses returns the stored byte on bus_rdata. Every other access returns 0 and changes no register.
- R3: For any address, exactly one of dev_sel[10:0] and dev_none is high. The dev_sel bits are:
  - 0: on-CPU RAM
  - 1: on-CPU mask ROM
  - 2: on-board SRAM
  - 3: on-board flash
  - 4: cartridge ROM
  - 5: expansion RAM
  - 6: expansion space
  - 7: expansion ROM
  - 8: video I/O
  - 9: on-chip peripherals
  - 10: clock-port I/O
- R4: 0x000000–0x0001FF selects on-board SRAM when speed-control bit 2 is 1. Otherwise it selects on-CPU RAM.
- R5: 0x000200–0x007FFF selects SRAM when control bit 5 is 1 and control bit 3 is 0. Otherwise it gives none.
- R6: With control bit 4 set, 0x008000–0x00DEFF selects flash when cart_n is 1 and cartridge ROM when cart_n is 0. With bit 4 clear it gives none.
- R7: 0x00E000–0x00FFFF routes as follows:
  - Bus-control bit 7 clear selects mask ROM.
  - Bus-control bit 7 set selects flash if control bit 4 is set.
  - Otherwise it selects SRAM if control bit 5 is set.
  - Otherwise it gives none.
- R8: When control bits 4 and 5 are both set, a write (bus_wr=1) to a window that R6 or R7 routes to ROM selects SRAM instead. Reads are unchanged.
- R9: Three windows are gated by control bits. Any other address in 0x1A0000–0x1FFFFF gives none.
  - 0x010000–0x19FFFF selects SRAM when control bit 5 is set.
  - 0x200000–0x3FFFFF selects expansion RAM when control bit 5 is set.
  - 0x400000–0xBFFFFF selects expansion space when control bit 6 is set.
- R10: With control bit 7 set, 0xC00000–0xC7FFFF selects flash and 0xC80000–0xFFFFFF selects expansion ROM. With bit 7 clear, both give none.
- R11: The three I/O windows are fixed:
  - 0x00DF00–0x00DF1F selects video I/O.
  - 0x00DF20–0x00DFBF selects peripherals.
  - 0x00DFC0–0x00DFFF selects clock-port I/O.
- R12: While flash is selected, flash_off equals bus_addr[18:0]. Otherwise it is 0. So 0xC08000 and 0x008000, and 0xC0E000 and 0x00E000, give equal offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 24 | CPU address |
| bus_en | input | 1 | Access valid, qualifies register access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read data |
| cart_n | input | 1 | Active-low cartridge present |
| dev_sel | output | 11 | One-hot device select |
| dev_none | output | 1 | No device claims the address |
| flash_off | output | 19 | Byte offset into on-board flash |

## Verification
On every cycle, the assertions check the following:
- exactly one target is high;
- the I/O windows and the unmapped hole are fixed;
- a write with both ROM and RAM enables lands in SRAM;
- the registers load only on a matching write and hold otherwise.

Only the bench's scenarios can show the remaining behaviour. This covers the full routing of each window under every combination of the relevant control bits, the cartridge pin and the direction, at both ends of each window. It also covers reset contents, register readback, and the equality of flash offsets across the mirrored windows.

// File: rtl/memmap_pkg.sv
// Shared definitions for the memory-map decoder: widths, window codes,
// select bit positions and configuration bit positions.
// Assumes a 24-bit byte address and 8-bit configuration registers.
package memmap_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 8;
    localparam int NSEL    = 11;
    localparam int FLASH_W = 19;

    typedef enum logic [3:0] {
        WIN_LOW, WIN_BASE, WIN_ROMLO, WIN_VID, WIN_PERI, WIN_CLKP,
        WIN_ROMHI, WIN_MAIN, WIN_XRAM, WIN_XSPC, WIN_FLASH, WIN_XROM,
        WIN_HOLE
    } win_e;

    localparam int S_CPU_RAM = 0;
    localparam int S_CPU_ROM = 1;
    localparam int S_SRAM    = 2;
    localparam int S_FLASH   = 3;
    localparam int S_CART    = 4;
    localparam int S_XRAM    = 5;
    localparam int S_XSPC    = 6;
    localparam int S_XROM    = 7;
    localparam int S_VID     = 8;
    localparam int S_PERI    = 9;
    localparam int S_CLKP    = 10;

    localparam int CB_BASE_BLK = 3;
    localparam int CB_ROM_EN   = 4;
    localparam int CB_RAM_EN   = 5;
    localparam int CB_XSPC_EN  = 6;
    localparam int CB_HIROM_EN = 7;
    localparam int BB_ROM_OVR  = 7;
    localparam int SB_LOW_SRAM = 2;

    // Only the configuration bits that steer routing.
    typedef struct packed {
        logic base_blk;
        logic rom_en;
        logic ram_en;
        logic xspc_en;
        logic hirom_en;
        logic rom_ovr;
        logic low_sram;
    } ctl_t;
endpackage

// File: rtl/memmap_cfg_regs.sv
// Configuration register file: three bytes at fixed bus addresses.
// Writes land on the clock edge of a qualified write; reads are combinational.
// Assumes the bus holds address and data stable around the edge.
module memmap_cfg_regs
    import memmap_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CSC_ADDR = 24'h00DF27,
    parameter logic [ADDR_W-1:0] BUS_ADDR = 24'h00DF40,
    parameter logic [ADDR_W-1:0] SPD_ADDR = 24'h00DF41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctl_t              ctl
);
    logic [DATA_W-1:0] csc_q, bus_q, spd_q;
    logic hit_csc, hit_bus, hit_spd;

    assign hit_csc = (addr == CSC_ADDR);
    assign hit_bus = (addr == BUS_ADDR);
    assign hit_spd = (addr == SPD_ADDR);

    // Load the addressed register on a qualified write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csc_q <= '0;
            bus_q <= '0;
            spd_q <= '0;
        end else if (en && wr) begin
            if (hit_csc) csc_q <= wdata;
            if (hit_bus) bus_q <= wdata;
            if (hit_spd) spd_q <= wdata;
        end
    end

    // Return the addressed register on a read, zero otherwise.
    always_comb begin
        rdata = '0;
        if (en && !wr) begin
            if (hit_csc) rdata = csc_q;
            else if (hit_bus) rdata = bus_q;
            else if (hit_spd) rdata = spd_q;
        end
    end

    // Expose the routing bits.
    assign ctl = '{base_blk: csc_q[CB_BASE_BLK], rom_en: csc_q[CB_ROM_EN],
                   ram_en: csc_q[CB_RAM_EN], xspc_en: csc_q[CB_XSPC_EN],
                   hirom_en: csc_q[CB_HIROM_EN], rom_ovr: bus_q[BB_ROM_OVR],
                   low_sram: spd_q[SB_LOW_SRAM]};

    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr && hit_csc) |=> (csc_q == $past(wdata)))
        else $error("control register did not load");
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && wr) |=> ($stable(csc_q) && $stable(bus_q) && $stable(spd_q)))
        else $error("register changed without a write");
endmodule

// File: rtl/memmap_window.sv
// Window classifier: maps an address to one of the fixed windows.
// Purely combinational; windows are checked in ascending address order.
module memmap_window
    import memmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output win_e              win
);
    // Classify by upper bound of each ascending window.
    always_comb begin
        if      (addr <= 24'h0001FF) win = WIN_LOW;
        else if (addr <= 24'h007FFF) win = WIN_BASE;
        else if (addr <= 24'h00DEFF) win = WIN_ROMLO;
        else if (addr <= 24'h00DF1F) win = WIN_VID;
        else if (addr <= 24'h00DFBF) win = WIN_PERI;
        else if (addr <= 24'h00DFFF) win = WIN_CLKP;
        else if (addr <= 24'h00FFFF) win = WIN_ROMHI;
        else if (addr <= 24'h19FFFF) win = WIN_MAIN;
        else if (addr <= 24'h1FFFFF) win = WIN_HOLE;
        else if (addr <= 24'h3FFFFF) win = WIN_XRAM;
        else if (addr <= 24'hBFFFFF) win = WIN_XSPC;
        else if (addr <= 24'hC7FFFF) win = WIN_FLASH;
        else                         win = WIN_XROM;
    end
endmodule

// File: rtl/memmap_route.sv
// Router: turns a window code, the routing bits, the cartridge pin and the
// access direction into a one-hot select or a "none" flag.
// Assumes the window code is valid; unknown codes route to none.
module memmap_route
    import memmap_pkg::*;
(
    input  win_e            win,
    input  logic            is_wr,
    input  logic            cart_n,
    input  ctl_t            ctl,
    output logic [NSEL-1:0] sel,
    output logic            none
);
    logic split_wr;
    assign split_wr = is_wr && ctl.rom_en && ctl.ram_en;

    // Pick the single target of the current window.
    always_comb begin
        sel = '0;
        unique case (win)
            WIN_LOW:   sel[ctl.low_sram ? S_SRAM : S_CPU_RAM] = 1'b1;
            WIN_BASE:  if (ctl.ram_en && !ctl.base_blk) sel[S_SRAM] = 1'b1;
            WIN_ROMLO: if (ctl.rom_en) begin
                           if (split_wr)    sel[S_SRAM]  = 1'b1;
                           else if (cart_n) sel[S_FLASH] = 1'b1;
                           else             sel[S_CART]  = 1'b1;
                       end
            WIN_VID:   sel[S_VID]  = 1'b1;
            WIN_PERI:  sel[S_PERI] = 1'b1;
            WIN_CLKP:  sel[S_CLKP] = 1'b1;
            WIN_ROMHI: if (!ctl.rom_ovr)  sel[S_CPU_ROM] = 1'b1;
                       else if (ctl.rom_en) sel[split_wr ? S_SRAM : S_FLASH] = 1'b1;
                       else if (ctl.ram_en) sel[S_SRAM] = 1'b1;
            WIN_MAIN:  if (ctl.ram_en)   sel[S_SRAM]  = 1'b1;
            WIN_XRAM:  if (ctl.ram_en)   sel[S_XRAM]  = 1'b1;
            WIN_XSPC:  if (ctl.xspc_en)  sel[S_XSPC]  = 1'b1;
            WIN_FLASH: if (ctl.hirom_en) sel[S_FLASH] = 1'b1;
            WIN_XROM:  if (ctl.hirom_en) sel[S_XROM]  = 1'b1;
            default:   sel = '0;
        endcase
    end

    // Flag unclaimed addresses.
    assign none = ~|sel;
endmodule

// File: rtl/memmap_decoder.sv
// Top of the memory-map decoder: register file, window classifier, router
// and flash offset. Decode is combinational; only registers are clocked.
// Assumes a synchronous active-low reset.
module memmap_decoder
    import memmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               cart_n,
    output logic [NSEL-1:0]    dev_sel,
    output logic               dev_none,
    output logic [FLASH_W-1:0] flash_off
);
    ctl_t ctl;
    win_e win;

    memmap_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .en(bus_en),
        .wr(bus_wr), .wdata(bus_wdata), .rdata(bus_rdata), .ctl(ctl));

    memmap_window u_win (.addr(bus_addr), .win(win));

    memmap_route u_route (
        .win(win), .is_wr(bus_wr), .cart_n(cart_n), .ctl(ctl),
        .sel(dev_sel), .none(dev_none));

    // Pass the low address bits to flash only while it is selected.
    assign flash_off = dev_sel[S_FLASH] ? bus_addr[FLASH_W-1:0] : '0;

    p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dev_none, dev_sel}) == 1)
        else $error("not exactly one target");
    p_io_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= 24'h00DF00 && bus_addr <= 24'h00DFFF) |->
        ($countones(dev_sel[S_CLKP:S_VID]) == 1))
        else $error("I/O window not selected");
    p_hole_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= 24'h1A0000 && bus_addr <= 24'h1FFFFF) |-> dev_none)
        else $error("hole claimed");
    p_split_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctl.rom_en && ctl.ram_en &&
         bus_addr >= 24'h008000 && bus_addr <= 24'h00DEFF) |-> dev_sel[S_SRAM])
        else $error("split write not routed to SRAM");
endmodule

// File: tb/memmap_decoder_tb.sv
// Directed bench for the memory-map decoder; one task per scenario.
module memmap_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cart_n = 1'b1;
    logic [10:0] dev_sel;
    logic        dev_none;
    logic [18:0] flash_off;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    int cyc = 0;

    memmap_decoder u_dut (.*);

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_en = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read_chk(input string req, input logic [23:0] a, input logic [7:0] exp);
        bus_addr = a; bus_en = 1'b1; bus_wr = 1'b0;
        #1 chk(req, {24'h0, bus_rdata}, {24'h0, exp});
        bus_en = 1'b0;
    endtask

    // Expected {none, sel} from the requirements.
    function automatic logic [11:0] model(input logic [23:0] a, input logic w,
            input logic [7:0] c, input logic [7:0] b, input logic [7:0] s, input logic cn);
        logic [11:0] r;
        logic rom = c[4], ram = c[5];
        r = '0;
        if (a <= 24'h0001FF)      r[s[2] ? 2 : 0] = 1'b1;
        else if (a <= 24'h007FFF) begin if (ram && !c[3]) r[2] = 1'b1; end
        else if (a <= 24'h00DEFF) begin
            if (rom) r[(w && ram) ? 2 : (cn ? 3 : 4)] = 1'b1;
        end
        else if (a <= 24'h00DF1F) r[8] = 1'b1;
        else if (a <= 24'h00DFBF) r[9] = 1'b1;
        else if (a <= 24'h00DFFF) r[10] = 1'b1;
        else if (a <= 24'h00FFFF) begin
            if (!b[7]) r[1] = 1'b1;
            else if (rom) r[(w && ram) ? 2 : 3] = 1'b1;
            else if (ram) r[2] = 1'b1;
        end
        else if (a <= 24'h19FFFF) begin if (ram) r[2] = 1'b1; end
        else if (a <= 24'h1FFFFF) r = '0;
        else if (a <= 24'h3FFFFF) begin if (ram) r[5] = 1'b1; end
        else if (a <= 24'hBFFFFF) begin if (c[6]) r[6] = 1'b1; end
        else if (a <= 24'hC7FFFF) begin if (c[7]) r[3] = 1'b1; end
        else begin if (c[7]) r[7] = 1'b1; end
        if (r[10:0] == '0) r[11] = 1'b1;
        return r;
    endfunction

    function automatic logic [23:0] edge_addr(input int i);
        case (i)
            0: return 24'h000000;  1: return 24'h0001FF;  2: return 24'h000200;
            3: return 24'h007FFF;  4: return 24'h008000;  5: return 24'h00DEFF;
            6: return 24'h00DF00;  7: return 24'h00DF1F;  8: return 24'h00DF20;
            9: return 24'h00DFBF; 10: return 24'h00DFC0; 11: return 24'h00DFFF;
           12: return 24'h00E000; 13: return 24'h00FFFF; 14: return 24'h010000;
           15: return 24'h19FFFF; 16: return 24'h1A0000; 17: return 24'h1FFFFF;
           18: return 24'h200000; 19: return 24'h3FFFFF; 20: return 24'h400000;
           21: return 24'hBFFFFF; 22: return 24'hC00000; 23: return 24'hC7FFFF;
           24: return 24'hC80000; default: return 24'hFFFFFF;
        endcase
    endfunction

    function automatic string req_of(input int i);
        if (i <= 1) return "R4";
        if (i <= 3) return "R5";
        if (i <= 5) return "R6/R8";
        if (i <= 11) return "R11";
        if (i <= 13) return "R7/R8";
        if (i <= 21) return "R9";
        return "R10";
    endfunction

    task automatic t_reset();
        bus_read_chk("R1 csc", 24'h00DF27, 8'h00);
        bus_read_chk("R1 bus", 24'h00DF40, 8'h00);
        bus_read_chk("R1 spd", 24'h00DF41, 8'h00);
        bus_addr = 24'h000000; #1 chk("R1 low", {dev_none, dev_sel}, 12'h001);
        bus_addr = 24'h00E000; #1 chk("R1 romhi", {dev_none, dev_sel}, 12'h002);
        bus_addr = 24'h008000; #1 chk("R1 romlo", {dev_none, dev_sel}, 12'h800);
    endtask

    task automatic t_regs();
        bus_write(24'h00DF27, 8'hA5);
        bus_write(24'h00DF40, 8'h3C);
        bus_write(24'h00DF41, 8'h81);
        bus_read_chk("R2 csc", 24'h00DF27, 8'hA5);
        bus_read_chk("R2 bus", 24'h00DF40, 8'h3C);
        bus_read_chk("R2 spd", 24'h00DF41, 8'h81);
        bus_write(24'h00DF28, 8'hFF);
        bus_write(24'h00DF42, 8'hFF);
        bus_read_chk("R2 csc unchanged", 24'h00DF27, 8'hA5);
        bus_read_chk("R2 spd unchanged", 24'h00DF41, 8'h81);
        bus_read_chk("R2 other reads 0", 24'h00DF26, 8'h00);
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 256; k++) begin
            logic [7:0] c = {k[4:0], 3'b000};
            logic [7:0] b = {k[5], 7'h00};
            logic [7:0] s = {5'h00, k[6], 2'b00};
            bus_write(24'h00DF27, c);
            bus_write(24'h00DF40, b);
            bus_write(24'h00DF41, s);
            cart_n = k[7];
            for (int w = 0; w < 2; w++) begin
                for (int i = 0; i < 26; i++) begin
                    logic [11:0] e;
                    bus_addr = edge_addr(i); bus_wr = w[0];
                    e = model(bus_addr, w[0], c, b, s, cart_n);
                    #1;
                    chk(req_of(i), {dev_none, dev_sel}, e);
                    chk("R3 one target", $countones({dev_none, dev_sel}), 1);
                    chk("R12 offset", flash_off, e[3] ? bus_addr[18:0] : 19'h0);
                end
            end
            bus_wr = 1'b0;
        end
        cart_n = 1'b1;
    endtask

    task automatic t_mirror();
        logic [18:0] lo, hi;
        bus_write(24'h00DF27, 8'h90);
        bus_write(24'h00DF40, 8'h80);
        bus_addr = 24'h008123; #1 lo = flash_off;
        bus_addr = 24'hC08123; #1 hi = flash_off;
        chk("R12 low rom mirror", hi, lo);
        chk("R12 low rom value", lo, 19'h08123);
        bus_addr = 24'h00F00F; #1 lo = flash_off;
        bus_addr = 24'hC0F00F; #1 hi = flash_off;
        chk("R12 high rom mirror", hi, lo);
        chk("R12 high rom value", lo, 19'h0F00F);
        cart_n = 1'b0;
        bus_addr = 24'h008123; #1 chk("R12 cart gives 0", flash_off, 19'h0);
        cart_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_sweep();
        t_mirror();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule